// File: doc/BRIEF.md
# Oscillator Drift Compensator for a Phase-Increment Generator

This block keeps a numerically controlled oscillator on frequency when its local sample clock drifts. A slow, stable reference clock enters the block asynchronously. It is synchronized into the local domain, and its rising edges are counted to form back-to-back measurement windows. Each window spans a fixed number of reference periods. During each window the block counts local clock cycles. When the window closes, it rescales the programmed base increment by the ratio of the expected local count to the measured one. The measured count changes from window to window, so the division runs on a bit-serial restoring divider and not as a multiply by a constant.

Software or a host block loads the base increment and issues a start pulse. From then on the block measures without further input. Each new increment is held back until the next window boundary. It is then loaded into the increment register and into the 32-bit phase accumulator's adder, and a one-cycle strobe marks the load. A window whose count is below a sanity floor is not divided. In that case the old increment stays in place and an error flag rises. With the default parameters, a 125 MHz local clock is measured against a 10 MHz reference over 16000 reference periods, which is 1.6 ms and 200000 expected local cycles. That keeps the correction well inside the 8 ms in which uncorrected drift would slip a full local cycle.

Top module: `ncoc_compensator`

## Requirements
- R1: While reset is asserted and right after it, `incOut`, `phaseAcc`, `incValid`, `busy` and `errFlag` are all zero.
- R2: A `startPulse` sampled high loads `incInit` into `incOut` and into the base increment. It clears `phaseAcc` and `errFlag`, drops any divide in progress or result not yet applied, and arms the gate. All of this is visible on the next cycle.
- R3: Once armed, the first synchronized rising edge of `refClk` opens a window. Each window closes after GATE_REF further rising edges, and the next window opens at the same edge. The measured count is the number of local cycles between the two boundary edges. The corrected increment is floor(base × NOMINAL / measured), computed at full width.
- R4: A result appears on `incOut` at the window boundary that follows the window it was measured in, together with a one-cycle `incValid` pulse. Every later window is processed the same way from the programmed base increment, so results never compound.
- R5: For each window with an accepted count, `busy` goes high in the cycle after the boundary. It stays high for exactly INC_W + clog2(NOMINAL+1) cycles.
- R6: A measured count below MIN_COUNT (zero included) starts no divide and leaves `incOut` unchanged. At that boundary `errFlag` goes high. It stays high until a window with a count at or above MIN_COUNT closes, which includes a count exactly equal to MIN_COUNT.
- R7: A quotient that does not fit in INC_W bits is applied as all ones.
- R8: `incOut` changes only in the cycle after a start pulse or in a cycle where `incValid` is high.
- R9: In every cycle not following a start pulse, `phaseAcc` advances by the previous cycle's `incOut`, modulo 2^INC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; all logic runs on it |
| rstN | input | 1 | Active-low reset |
| refClk | input | 1 | Stable reference clock, asynchronous to clk |
| startPulse | input | 1 | Loads incInit and arms the measurement |
| incInit | input | INC_W | Programmed base phase increment |
| incOut | output | INC_W | Increment currently applied to the accumulator |
| incValid | output | 1 | One-cycle pulse when a corrected increment is loaded |
| phaseAcc | output | INC_W | Phase accumulator |
| busy | output | 1 | Divider running |
| errFlag | output | 1 | Last closed window had a count below the sanity floor |

## Verification
The bound checker watches four things on every cycle: that the accumulator steps by the applied increment, that the increment holds between loads, that the load strobe lasts a single cycle, and that a divide never runs longer than its fixed length. It also checks that a rejected window never launches a divide. The value of each corrected increment depends on the ratio of reference to local period. The bench's scenarios alone show that value and the saturation. They also show the exact ratio of one, the acceptance of a count equal to the floor, and recovery after bad windows. To do this they drive reference periods with random and directed values and compare against a quotient computed in the bench.

// File: rtl/ncoc_pkg.sv
package ncoc_pkg;
  // Strobes from the window control to the datapath
  typedef struct packed {
    logic restart;   // load base increment, clear state
    logic launch;    // start a divide with the measured count
    logic apply;     // window boundary: load pending result
  } ncoc_strobe_t;
endpackage

// File: rtl/ncoc_edge_sync.sv
module ncoc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], asyncIn};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ncoc_ctrl.sv
module ncoc_ctrl
  import ncoc_pkg::*;
#(
  parameter int GATE_REF  = 16000,
  parameter int MIN_COUNT = 100000,
  parameter int CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             refRise,
  output ncoc_strobe_t     strobe,
  output logic [CNT_W-1:0] measured,
  output logic             errFlag
);
  localparam int REF_W    = (GATE_REF > 2) ? $clog2(GATE_REF) : 1;
  localparam int REF_LAST = GATE_REF - 1;

  typedef enum logic [1:0] {GATE_IDLE, GATE_ARM, GATE_RUN} gate_e;

  gate_e            state;
  logic [REF_W-1:0] refCnt;
  logic [CNT_W-1:0] localCnt;
  logic             boundary;
  logic             minOk;

  always_comb begin
    // count including the boundary cycle, saturating
    measured = (&localCnt) ? localCnt : localCnt + 1'b1;
    boundary = (state == GATE_RUN) && refRise && (refCnt == REF_W'(REF_LAST));
    minOk    = ({1'b0, measured} >= (CNT_W+1)'(MIN_COUNT));
    strobe.restart = startPulse;
    strobe.apply   = boundary && !startPulse;
    strobe.launch  = boundary && !startPulse && minOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= GATE_IDLE;
      refCnt   <= '0;
      localCnt <= '0;
      errFlag  <= 1'b0;
    end else if (startPulse) begin
      state    <= GATE_ARM;
      refCnt   <= '0;
      localCnt <= '0;
      errFlag  <= 1'b0;
    end else begin
      case (state)
        GATE_ARM: begin
          if (refRise) begin
            state    <= GATE_RUN;
            refCnt   <= '0;
            localCnt <= '0;
          end
        end
        GATE_RUN: begin
          localCnt <= boundary ? '0 : measured;
          if (refRise) refCnt <= boundary ? '0 : refCnt + 1'b1;
          if (boundary) errFlag <= !minOk;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ncoc_datapath.sv
module ncoc_datapath
  import ncoc_pkg::*;
#(
  parameter int INC_W   = 32,
  parameter int NOMINAL = 200000,
  parameter int CNT_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoc_strobe_t     strobe,
  input  logic [CNT_W-1:0] measured,
  input  logic [INC_W-1:0] incInit,
  output logic [INC_W-1:0] incOut,
  output logic             incValid,
  output logic [INC_W-1:0] phaseAcc,
  output logic             busy
);
  localparam int NOM_W  = $clog2(NOMINAL + 1);
  localparam int PW     = INC_W + NOM_W;
  localparam int STEP_W = $clog2(PW + 1);

  logic [INC_W-1:0]  baseInc;
  logic [INC_W-1:0]  resQ;
  logic              resValid;
  logic [PW-1:0]     quo;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  divisor;
  logic [STEP_W-1:0] step;

  logic [CNT_W:0]    trial;
  logic              takeBit;
  logic [CNT_W-1:0]  remNext;
  logic [PW-1:0]     quoNext;
  logic [INC_W-1:0]  quoSat;

  // One restoring step: shift in a dividend bit, subtract if it fits
  always_comb begin
    trial   = {rem, quo[PW-1]};
    takeBit = (trial >= {1'b0, divisor});
    remNext = takeBit ? CNT_W'(trial - {1'b0, divisor}) : trial[CNT_W-1:0];
    quoNext = {quo[PW-2:0], takeBit};
    quoSat  = (|quoNext[PW-1:INC_W]) ? '1 : quoNext[INC_W-1:0];
  end

  // Divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      quo      <= '0;
      rem      <= '0;
      divisor  <= '0;
      step     <= '0;
      resQ     <= '0;
      resValid <= 1'b0;
    end else if (strobe.restart) begin
      busy     <= 1'b0;
      resValid <= 1'b0;
    end else begin
      if (strobe.apply) resValid <= 1'b0;
      if (strobe.launch) begin
        quo     <= PW'(baseInc) * PW'(NOMINAL);
        rem     <= '0;
        divisor <= measured;
        step    <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        quo <= quoNext;
        rem <= remNext;
        if (step == STEP_W'(PW - 1)) begin
          busy     <= 1'b0;
          resQ     <= quoSat;
          resValid <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  // Increment register and phase accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseInc  <= '0;
      incOut   <= '0;
      incValid <= 1'b0;
      phaseAcc <= '0;
    end else if (strobe.restart) begin
      baseInc  <= incInit;
      incOut   <= incInit;
      incValid <= 1'b0;
      phaseAcc <= '0;
    end else begin
      phaseAcc <= phaseAcc + incOut;
      incValid <= strobe.apply && resValid;
      if (strobe.apply && resValid) incOut <= resQ;
    end
  end
endmodule

// File: rtl/ncoc_compensator.sv
module ncoc_compensator
  import ncoc_pkg::*;
#(
  parameter int INC_W     = 32,
  parameter int NOMINAL   = 200000,
  parameter int GATE_REF  = 16000,
  parameter int MIN_COUNT = 100000,
  parameter int CNT_W     = 20,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClk,
  input  logic             startPulse,
  input  logic [INC_W-1:0] incInit,
  output logic [INC_W-1:0] incOut,
  output logic             incValid,
  output logic [INC_W-1:0] phaseAcc,
  output logic             busy,
  output logic             errFlag
);
  logic             refRise;
  ncoc_strobe_t     strobe;
  logic [CNT_W-1:0] measured;

  ncoc_edge_sync #(.STAGES(SYNC_STG)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(refClk), .rise(refRise)
  );

  ncoc_ctrl #(.GATE_REF(GATE_REF), .MIN_COUNT(MIN_COUNT), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .refRise(refRise),
    .strobe(strobe), .measured(measured), .errFlag(errFlag)
  );

  ncoc_datapath #(.INC_W(INC_W), .NOMINAL(NOMINAL), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .measured(measured),
    .incInit(incInit), .incOut(incOut), .incValid(incValid),
    .phaseAcc(phaseAcc), .busy(busy)
  );
endmodule

// File: rtl/ncoc_compensator_chk.sv
module ncoc_compensator_chk #(
  parameter int INC_W   = 32,
  parameter int NOMINAL = 200000
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [INC_W-1:0] incOut,
  input logic             incValid,
  input logic [INC_W-1:0] phaseAcc,
  input logic             busy,
  input logic             errFlag
);
  localparam int PW    = INC_W + $clog2(NOMINAL + 1);
  localparam int RUN_W = $clog2(PW + 2) + 1;

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy && busyRun != '1) busyRun <= busyRun + 1'b1;
    else if (!busy) busyRun <= '0;
  end

  // R4: load strobe lasts one cycle
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    incValid |=> !incValid);

  // R8: increment holds unless loaded
  assert_inc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!incValid && !$past(startPulse)) |-> (incOut == $past(incOut)));

  // R9: accumulator steps by applied increment
  assert_phase_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(startPulse) |-> (INC_W'(phaseAcc - $past(phaseAcc)) == $past(incOut)));

  // R5: divide never exceeds its fixed length
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < RUN_W'(PW)));

  // R6: rejected window launches no divide
  assert_err_no_div_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy);
endmodule

bind ncoc_compensator ncoc_compensator_chk #(.INC_W(INC_W), .NOMINAL(NOMINAL)) uChk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .incOut(incOut),
  .incValid(incValid), .phaseAcc(phaseAcc), .busy(busy), .errFlag(errFlag)
);

// File: tb/tb_ncoc_compensator.sv
module tb_ncoc_compensator;
  localparam int INC_W = 32;
  localparam int NOM   = 200;
  localparam int GATE  = 20;
  localparam int MINC  = 100;
  localparam int CNT_W = 12;
  localparam int PW    = INC_W + $clog2(NOM + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             refClk = 1'b0;
  logic             startPulse = 1'b0;
  logic [INC_W-1:0] incInit = '0;
  logic [INC_W-1:0] incOut;
  logic             incValid;
  logic [INC_W-1:0] phaseAcc;
  logic             busy;
  logic             errFlag;

  int nChecks = 0;
  int nFail = 0;
  int refPer = 10;
  int validCnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ncoc_compensator #(.INC_W(INC_W), .NOMINAL(NOM), .GATE_REF(GATE),
                     .MIN_COUNT(MINC), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .startPulse(startPulse),
    .incInit(incInit), .incOut(incOut), .incValid(incValid),
    .phaseAcc(phaseAcc), .busy(busy), .errFlag(errFlag)
  );

  // reference clock: rising edge every refPer local cycles
  initial begin
    forever begin
      @(negedge clk) refClk = 1'b1;
      repeat (refPer / 2 - 1) @(negedge clk);
      @(negedge clk) refClk = 1'b0;
      repeat (refPer - refPer / 2 - 1) @(negedge clk);
    end
  end

  always @(negedge clk) if (incValid) validCnt++;

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint expInc(input longint base, input int p);
    longint q;
    q = (base * NOM) / (GATE * p);
    return (q > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : q;
  endfunction

  task automatic waitValid(input string tag);
    bit got = 0;
    for (int i = 0; i < 6000 && !got; i++) begin
      @(negedge clk);
      if (incValid) got = 1;
    end
    if (!got) check({tag, " valid timeout"}, 0, 1);
  endtask

  task automatic doStart(input logic [INC_W-1:0] base);
    @(negedge clk);
    startPulse = 1'b1;
    incInit = base;
    @(negedge clk);
    startPulse = 1'b0;
    check("R2 incOut after start", incOut, base);
    check("R2 phase cleared", phaseAcc, 0);
    check("R2 err cleared", errFlag, 0);
  endtask

  task automatic runPhase(input logic [INC_W-1:0] base, input int p);
    longint exp;
    int n;
    logic [INC_W-1:0] p0, i0;
    exp = expInc(base, p);
    refPer = p;
    repeat (48) @(negedge clk);
    doStart(base);
    waitValid("R3");
    check("R3 corrected increment", incOut, exp);
    check("R6 no error on good window", errFlag, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R5 busy length", n, PW);
    p0 = phaseAcc; i0 = incOut;
    repeat (20) @(negedge clk);
    check("R8 increment held in window", incOut, i0);
    check("R9 phase advance", INC_W'(phaseAcc - p0), INC_W'(i0 * 20));
    waitValid("R4");
    check("R4 second window no compounding", incOut, exp);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check("R1 incOut reset", incOut, 0);
    check("R1 phase reset", phaseAcc, 0);
    check("R1 flags reset", {incValid, busy, errFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {incValid, busy, errFlag, incOut}, 0);

    // exact nominal ratio
    runPhase(32'h1000_0000, 10);
    // saturation, count equal to floor accepted (R6/R7)
    runPhase(32'hF000_0000, 5);
    check("R7 saturated to all ones", incOut, 32'hFFFF_FFFF);

    // random drift
    for (int i = 0; i < 8; i++) begin
      logic [INC_W-1:0] b;
      int p;
      b = $urandom;
      p = 8 + int'($urandom % 7);
      runPhase(b, p);
    end

    // sanity floor: window count 60 < 100
    refPer = 3;
    repeat (48) @(negedge clk);
    doStart(32'h0ABC_DEF0);
    validCnt = 0;
    repeat (800) @(negedge clk);
    check("R6 error flag set", errFlag, 1);
    check("R6 increment kept", incOut, 32'h0ABC_DEF0);
    check("R6 no load strobe", validCnt, 0);
    // recovery without restart
    refPer = 12;
    waitValid("R6 recovery");
    waitValid("R6 recovery");
    check("R6 error flag cleared", errFlag, 0);
    check("R6 increment after recovery", incOut, expInc(32'h0ABC_DEF0, 12));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule